// File: doc/BRIEF.md
# Radio-Aware Pin Bank Controller

This block owns a bank of general-purpose pins split into two halves. One half sits beside the transmit chain and the other beside the receive chain. Each pin has its own direction bit. When a pin is an output, a per-pin two-bit code picks what drives it: a software-written data word, an automatic pattern that follows the radio's activity, or one of two debug buses. A pin that is not an output is never driven.

The automatic source holds four programmable patterns per half: one for idle, one for transmit only, one for receive only and one for full duplex. Two status inputs, transmit-active and receive-active, pick the pattern. The chosen pattern is registered, so antenna switches, amplifier enables and similar lines follow the radio state one clock after a status change. Software needs no further action once the patterns are set. The current pin input levels are sampled into a readback word every clock.

Configuration is through a simple single-cycle write port. Every configuration register clears to zero on reset.

Top module: `radio_pin_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no writes: pad_oe is all zero, pad_out is all zero and rd_pins is all zero.
- R2: A write to address 1 loads the direction word, and pad_oe equals it from the next clock. A pin whose direction bit is 0 has pad_out 0 whatever its source.
- R3: Select code 0 drives the pin from the software data word at address 0. A write to that word shows on pad_out one clock after the write cycle.
- R4: Select code 2 drives the pin from the same bit of dbg0, and code 3 from the same bit of dbg1. Both paths are combinational, so a change on dbg0 or dbg1 shows on pad_out in the same cycle.
- R5: Select code 1 drives the pin from the automatic pattern. The pattern is chosen by {rx_active, tx_active}: 00 gives idle, 01 gives transmit only, 10 gives receive only and 11 gives full duplex.
- R6: A change of tx_active or rx_active reaches pad_out one clock later. In the cycle of the change, pad_out still shows the previous pattern.
- R7: Pins 0..15 form the transmit half. Their select codes are in the word at address 2, and pin i uses bits [2i+1:2i]. Their patterns are at addresses 4, 5, 6 and 7 (idle, tx only, rx only, duplex), in data bits [15:0]. Pins 16..31 form the receive half. Their select word is at address 3, and pin 16+j uses bits [2j+1:2j]. Their patterns are at addresses 8 to 11 in the same order.
- R8: rd_pins equals pad_in as sampled at the previous clock edge.
- R9: Writes to addresses 12 to 15 change nothing, and neither does any cycle with wr_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| tx_active | input | 1 | Transmit chain active |
| rx_active | input | 1 | Receive chain active |
| dbg0 | input | 32 | Debug bus 0, one bit per pin |
| dbg1 | input | 32 | Debug bus 1, one bit per pin |
| pad_in | input | 32 | Pin input levels from the pads |
| pad_out | output | 32 | Pin output values |
| pad_oe | output | 32 | Pin output enables |
| rd_pins | output | 32 | Registered pin input levels |

## Verification
A corrupted pattern register or a wrong registered pattern shows on every auto-selected pin one clock after the status inputs settle. A half-swap or a misdecoded address shows as the wrong half's pattern on the wrong pins, and the distinct patterns per half expose it at once. A wrong select code or direction bit is visible on that single pin in the cycle after the write, with debug-sourced pins showing it without any clock delay. A status path that is too fast or too slow is caught by sampling pad_out both before and after the edge that follows a status change.

// File: rtl/radio_pin_pkg.sv
package radio_pin_pkg;

    localparam int ADDR_W = 4;
    localparam int SIDES  = 2;
    localparam int SIDE_TX = 0;
    localparam int SIDE_RX = 1;

    // register map
    localparam logic [ADDR_W-1:0] A_SW_DATA = 4'd0;
    localparam logic [ADDR_W-1:0] A_DIR     = 4'd1;
    localparam logic [ADDR_W-1:0] A_SEL_TX  = 4'd2;
    localparam logic [ADDR_W-1:0] A_SEL_RX  = 4'd3;
    // pattern banks decoded from address bits [3:2]
    localparam logic [1:0] PAT_BANK_TX = 2'd1;
    localparam logic [1:0] PAT_BANK_RX = 2'd2;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_AUTO = 2'd1,
        SRC_DBG0 = 2'd2,
        SRC_DBG1 = 2'd3
    } pin_src_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TX_ONLY = 2'd1,
        ST_RX_ONLY = 2'd2,
        ST_DUPLEX  = 2'd3
    } radio_state_e;

    function automatic radio_state_e state_of(input logic tx, input logic rx);
        return radio_state_e'({rx, tx});
    endfunction

endpackage

// File: rtl/radio_pin_cfg.sv
module radio_pin_cfg
    import radio_pin_pkg::*;
#(
    parameter  int NS = 16,
    localparam int NP = 2 * NS
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [NP-1:0]                   wr_data,
    output logic [NP-1:0]                   sw_o,
    output logic [NP-1:0]                   dir_o,
    output logic [SIDES-1:0][NP-1:0]        sel_o,
    output logic [SIDES-1:0][3:0][NS-1:0]   pat_o
);

    typedef struct packed {
        logic [NP-1:0]                 sw;
        logic [NP-1:0]                 dir;
        logic [SIDES-1:0][NP-1:0]      sel;
        logic [SIDES-1:0][3:0][NS-1:0] pat;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == A_SW_DATA) begin
                cfg_d.sw = wr_data;
            end else if (wr_addr == A_DIR) begin
                cfg_d.dir = wr_data;
            end else if (wr_addr == A_SEL_TX) begin
                cfg_d.sel[SIDE_TX] = wr_data;
            end else if (wr_addr == A_SEL_RX) begin
                cfg_d.sel[SIDE_RX] = wr_data;
            end else if (wr_addr[ADDR_W-1:2] == PAT_BANK_TX) begin
                cfg_d.pat[SIDE_TX][wr_addr[1:0]] = wr_data[NS-1:0];
            end else if (wr_addr[ADDR_W-1:2] == PAT_BANK_RX) begin
                cfg_d.pat[SIDE_RX][wr_addr[1:0]] = wr_data[NS-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign sw_o  = cfg_q.sw;
    assign dir_o = cfg_q.dir;
    assign sel_o = cfg_q.sel;
    assign pat_o = cfg_q.pat;

endmodule

// File: rtl/radio_pin_auto.sv
module radio_pin_auto
    import radio_pin_pkg::*;
#(
    parameter int NS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0][NS-1:0]   pat_i,
    input  logic                 tx_active,
    input  logic                 rx_active,
    output logic [NS-1:0]        auto_o
);

    typedef struct packed {
        logic [NS-1:0] drive;
    } auto_t;

    auto_t a_d, a_q;
    radio_state_e st;

    always_comb begin
        st = state_of(tx_active, rx_active);
        a_d = a_q;
        unique case (st)
            ST_IDLE:    a_d.drive = pat_i[ST_IDLE];
            ST_TX_ONLY: a_d.drive = pat_i[ST_TX_ONLY];
            ST_RX_ONLY: a_d.drive = pat_i[ST_RX_ONLY];
            ST_DUPLEX:  a_d.drive = pat_i[ST_DUPLEX];
            default:    a_d.drive = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign auto_o = a_q.drive;

endmodule

// File: rtl/radio_pin_mux.sv
module radio_pin_mux
    import radio_pin_pkg::*;
#(
    parameter  int NS = 16,
    localparam int NP = 2 * NS
) (
    input  logic [NP-1:0]              sw_i,
    input  logic [NP-1:0]              dir_i,
    input  logic [SIDES-1:0][NP-1:0]   sel_i,
    input  logic [SIDES-1:0][NS-1:0]   auto_i,
    input  logic [NP-1:0]              dbg0_i,
    input  logic [NP-1:0]              dbg1_i,
    output logic [NP-1:0]              pad_out_o,
    output logic [NP-1:0]              pad_oe_o
);

    for (genvar p = 0; p < NP; p++) begin : g_pin
        localparam int S = p / NS;
        localparam int J = p % NS;
        pin_src_e src;
        logic     drv;

        always_comb begin
            src = pin_src_e'(sel_i[S][2*J +: 2]);
            unique case (src)
                SRC_SW:   drv = sw_i[p];
                SRC_AUTO: drv = auto_i[S][J];
                SRC_DBG0: drv = dbg0_i[p];
                SRC_DBG1: drv = dbg1_i[p];
                default:  drv = 1'b0;
            endcase
        end

        assign pad_out_o[p] = dir_i[p] & drv;
        assign pad_oe_o[p]  = dir_i[p];
    end

endmodule

// File: rtl/radio_pin_ctrl.sv
module radio_pin_ctrl
    import radio_pin_pkg::*;
#(
    parameter  int NS = 16,
    localparam int NP = 2 * NS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NP-1:0]     wr_data,
    input  logic              tx_active,
    input  logic              rx_active,
    input  logic [NP-1:0]     dbg0,
    input  logic [NP-1:0]     dbg1,
    input  logic [NP-1:0]     pad_in,
    output logic [NP-1:0]     pad_out,
    output logic [NP-1:0]     pad_oe,
    output logic [NP-1:0]     rd_pins
);

    logic [NP-1:0]                 sw_w;
    logic [NP-1:0]                 dir_w;
    logic [SIDES-1:0][NP-1:0]      sel_w;
    logic [SIDES-1:0][3:0][NS-1:0] pat_w;
    logic [SIDES-1:0][NS-1:0]      auto_w;

    radio_pin_cfg #(.NS(NS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sw_o    (sw_w),
        .dir_o   (dir_w),
        .sel_o   (sel_w),
        .pat_o   (pat_w)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        radio_pin_auto #(.NS(NS)) u_auto (
            .clk       (clk),
            .rst_n     (rst_n),
            .pat_i     (pat_w[s]),
            .tx_active (tx_active),
            .rx_active (rx_active),
            .auto_o    (auto_w[s])
        );
    end

    radio_pin_mux #(.NS(NS)) u_mux (
        .sw_i      (sw_w),
        .dir_i     (dir_w),
        .sel_i     (sel_w),
        .auto_i    (auto_w),
        .dbg0_i    (dbg0),
        .dbg1_i    (dbg1),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe)
    );

    // input sampling
    typedef struct packed {
        logic [NP-1:0] pins;
    } samp_t;

    samp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.pins = pad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign rd_pins = smp_q.pins;

endmodule

// File: rtl/radio_pin_ctrl_chk.sv
module radio_pin_ctrl_chk
    import radio_pin_pkg::*;
#(
    parameter  int NS = 16,
    localparam int NP = 2 * NS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [NP-1:0]     wr_data,
    input logic              tx_active,
    input logic              rx_active,
    input logic [NP-1:0]     dbg0,
    input logic [NP-1:0]     dbg1,
    input logic [NP-1:0]     pad_in,
    input logic [NP-1:0]     pad_out,
    input logic [NP-1:0]     pad_oe,
    input logic [NP-1:0]     rd_pins
);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && rd_pins == '0));

    p_oe_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DIR) |=> (pad_oe == $past(wr_data)));

    p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    p_rd_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rst_n) |-> (rd_pins == $past(pad_in)));

    // R6: with no writes and steady status and debug inputs, pins hold
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wr_en) && $past(!wr_en, 2)
         && $past(tx_active) == $past(tx_active, 2)
         && $past(rx_active) == $past(rx_active, 2)
         && $stable(dbg0) && $stable(dbg1)) |-> $stable(pad_out));

endmodule

bind radio_pin_ctrl radio_pin_ctrl_chk #(.NS(NS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .tx_active (tx_active),
    .rx_active (rx_active),
    .dbg0      (dbg0),
    .dbg1      (dbg1),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .rd_pins   (rd_pins)
);

// File: tb/radio_pin_ctrl_tb.sv
module radio_pin_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tx_active = 1'b0;
    logic        rx_active = 1'b0;
    logic [31:0] dbg0 = '0;
    logic [31:0] dbg1 = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] rd_pins;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    radio_pin_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_active(tx_active), .rx_active(rx_active),
        .dbg0(dbg0), .dbg1(dbg1), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .rd_pins(rd_pins)
    );

    // {tx_active, rx_active, expected pad_out}
    localparam logic [33:0] VEC [8] = '{
        {1'b0, 1'b0, 32'hA001_1111},
        {1'b1, 1'b0, 32'hB002_2222},
        {1'b0, 1'b1, 32'hC003_4444},
        {1'b1, 1'b1, 32'hD004_8888},
        {1'b0, 1'b0, 32'hA001_1111},
        {1'b1, 1'b1, 32'hD004_8888},
        {1'b0, 1'b1, 32'hC003_4444},
        {1'b1, 1'b0, 32'hB002_2222}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", pad_oe, 32'h0);
        chk("R1 out in reset", pad_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", pad_oe, 32'h0);
        chk("R1 rd after reset", rd_pins, 32'h0);

        // R8 input sampling
        pad_in = 32'h1357_2468;
        #1 chk("R8 not before edge", rd_pins, 32'h0);
        @(negedge clk);
        chk("R8 sampled", rd_pins, 32'h1357_2468);

        // R3 software source
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd0, 32'hDEAD_BEEF);
        chk("R3 sw data", pad_out, 32'hDEAD_BEEF);
        chk("R2 oe all", pad_oe, 32'hFFFF_FFFF);

        // R2 direction masking
        wr(4'd1, 32'h0000_FFFF);
        chk("R2 oe half", pad_oe, 32'h0000_FFFF);
        chk("R2 masked out", pad_out, 32'h0000_BEEF);
        wr(4'd1, 32'hFFFF_FFFF);

        // R4 debug sources
        dbg0 = 32'h1234_5678;
        dbg1 = 32'h9ABC_DEF0;
        wr(4'd2, 32'hAAAA_AAAA);
        wr(4'd3, 32'hFFFF_FFFF);
        chk("R4 dbg halves", pad_out, 32'h9ABC_5678);
        @(negedge clk);
        dbg0 = 32'h0000_FFFF;
        dbg1 = 32'h0F0F_0000;
        #1 chk("R4 same cycle", pad_out, 32'h0F0F_FFFF);

        // R7 per-pin select fields on the transmit half
        dbg0 = 32'hFFFF_FFFF;
        dbg1 = 32'hFFFF_FFFF;
        wr(4'd0, 32'h0000_0001);
        wr(4'd4, 32'h0000_FFFF);
        wr(4'd3, 32'h0000_0000);
        wr(4'd2, 32'h0000_00E4);
        chk("R7 mixed codes", pad_out, 32'h0000_000F);
        wr(4'd0, 32'h0000_0000);
        chk("R3 R7 sw bit cleared", pad_out, 32'h0000_000E);

        // R9 ignored writes
        wr(4'd12, 32'hFFFF_FFFF);
        wr(4'd15, 32'hFFFF_FFFF);
        chk("R9 unused addr out", pad_out, 32'h0000_000E);
        chk("R9 unused addr oe", pad_oe, 32'hFFFF_FFFF);
        @(negedge clk);
        wr_addr = 4'd1; wr_data = 32'h0;
        @(negedge clk);
        chk("R9 no strobe", pad_oe, 32'hFFFF_FFFF);

        // R5 R7 automatic patterns, table driven
        wr(4'd4, 32'h0000_1111);
        wr(4'd5, 32'h0000_2222);
        wr(4'd6, 32'h0000_4444);
        wr(4'd7, 32'h0000_8888);
        wr(4'd8, 32'h0000_A001);
        wr(4'd9, 32'h0000_B002);
        wr(4'd10, 32'h0000_C003);
        wr(4'd11, 32'h0000_D004);
        wr(4'd2, 32'h5555_5555);
        wr(4'd3, 32'h5555_5555);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            tx_active = VEC[i][33];
            rx_active = VEC[i][32];
            @(negedge clk);
            chk("R5 R7 pattern", pad_out, VEC[i][31:0]);
        end

        // R6 one-clock latency of a status change (state now tx only)
        @(negedge clk);
        tx_active = 1'b0;
        rx_active = 1'b1;
        #1 chk("R6 old pattern held", pad_out, 32'hB002_2222);
        @(negedge clk);
        chk("R6 new pattern", pad_out, 32'hC003_4444);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule